// File: doc/BRIEF.md
# Maskable Interrupt Arbitration Unit

This unit sits beside a small 8-bit processor core and decides, each time an instruction finishes, whether the core should enter interrupt service and through which vector. It watches three sources: an active-low external request line, a request from the on-chip timer, and an indication from the decoder that the finishing instruction was a software interrupt.

The unit owns the interrupt mask bit. One mask bit blocks both hardware sources together. Hardware requests that arrive while they are blocked are held in per-source pending latches and are serviced at the first instruction boundary after the mask drops. Entering service sets the mask. The core's return-from-interrupt sequence writes the mask back from the stacked copy.

The core answers each grant with an acknowledge pulse once it has stacked its registers and fetched the vector. That acknowledge clears the pending latch of the source that was granted. The software interrupt is not blocked by the mask. However, an unmasked hardware request wins over it at the same boundary.

Top module: `intr_arbiter`

## Requirements
- R1: After reset the mask bit reads 1, take_int is 0, vector_sel is 0 and both pending latches are empty. Clearing the mask and then signalling a boundary with no request gives no grant.
- R2: The external line passes through a two-stage synchronizer. Only a high-to-low transition sets the external pending latch, and the latch is set on the third rising clock edge after the line falls. Holding the line low does not set the latch again.
- R3: A timer_req high in any cycle sets the timer pending latch at that clock edge.
- R4: Grants are decided only in a cycle with instr_done high, using the latches and mask as they stood before that edge. take_int is a single-cycle pulse in the cycle after that boundary.
- R5: While the mask is 1, neither hardware source is granted. Their latches keep their requests, which are granted at the first boundary after the mask returns to 0.
- R6: When both hardware latches are pending at an unmasked boundary, the external source is granted first. vector_sel codes are 1 for external, 2 for timer and 3 for software.
- R7: Every grant sets the mask bit to 1 in the same cycle that take_int rises.
- R8: instr_done together with swi_decode produces a grant with code 3 whatever the mask. If an unmasked hardware request is pending at that boundary, the hardware source is granted instead.
- R9: rti_restore_i loads the mask from rti_mask_i at the next edge. If a grant happens in the same cycle, the mask becomes 1.
- R10: ack clears only the pending latch of the source last granted, and only while a grant is awaiting acknowledge. A new request to that source in the same cycle as ack keeps its latch set. An ack with no grant outstanding changes nothing.
- R11: After a grant, no further grant is made until ack is received.
- R12: vector_sel keeps the last granted code until the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | External interrupt line, active low, asynchronous |
| timer_req | input | 1 | Timer interrupt request |
| instr_done | input | 1 | Current instruction completes this cycle |
| swi_decode | input | 1 | Completing instruction is a software interrupt |
| rti_restore_i | input | 1 | Return-from-interrupt is restoring the mask |
| rti_mask_i | input | 1 | Mask value popped from the stack |
| ack | input | 1 | Core has entered service for the last grant |
| take_int | output | 1 | One-cycle pulse: start interrupt processing |
| vector_sel | output | 2 | Vector code of the last grant |
| mask_o | output | 1 | Current interrupt mask bit |

## Verification
A wrong pending latch stays hidden while the mask is set. It shows only at the first unmasked boundary, either as a missing grant or as a grant with the wrong vector code. A wrong busy state or mask bit shows at the very next boundary as an extra or absent take_int pulse. For this reason the bench mixes long masked stretches with boundaries, acknowledges and restores, and it compares every output against a behavioural model on every cycle.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;

    localparam int HW_SRC = 2;   // index 0 external, index 1 timer
    localparam int VEC_W  = 2;

    typedef enum logic [VEC_W-1:0] {
        VEC_NONE = 2'd0,
        VEC_EXT  = 2'd1,
        VEC_TMR  = 2'd2,
        VEC_SWI  = 2'd3
    } vec_e;

    typedef struct packed {
        logic mask;
        logic take;
        logic busy;
        vec_e vsel;
    } arb_state_t;

    function automatic vec_e vec_of(input int idx);
        logic [VEC_W-1:0] code;
        code = idx[VEC_W-1:0] + 2'd1;
        return vec_e'(code);
    endfunction

endpackage

// File: rtl/intr_sync_edge.sv
module intr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic fall_o
);
    localparam int TOP = STAGES;

    typedef struct packed {
        logic [TOP:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[TOP-1:0], async_n};
        fall_o     = st_q.chain[TOP] & ~st_q.chain[TOP-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: '1};
        else        st_q <= st_d;
    end

    // R2
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/intr_pend_latch.sv
module intr_pend_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic pend;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = set_i | (st_q.pend & ~clr_i);
        pend_o    = st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: 1'b0};
        else        st_q <= st_d;
    end

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o && !clr_i |=> pend_o);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

endmodule

// File: rtl/intr_pick.sv
module intr_pick
    import intr_arb_pkg::*;
(
    input  logic [HW_SRC-1:0] pend_i,
    input  logic              mask_i,
    input  logic              swi_i,
    output logic              hw_ok_o,
    output logic              any_o,
    output vec_e              vec_o
);
    always_comb begin
        hw_ok_o = ~mask_i & (|pend_i);
        vec_o   = VEC_SWI;
        if (hw_ok_o) begin
            for (int i = HW_SRC - 1; i >= 0; i--) begin
                if (pend_i[i]) vec_o = vec_of(i);
            end
        end
        any_o = hw_ok_o | swi_i;
    end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_n,
    input  logic             timer_req,
    input  logic             instr_done,
    input  logic             swi_decode,
    input  logic             rti_restore_i,
    input  logic             rti_mask_i,
    input  logic             ack,
    output logic             take_int,
    output logic [VEC_W-1:0] vector_sel,
    output logic             mask_o
);
    logic              ext_fall;
    logic [HW_SRC-1:0] src_set;
    logic [HW_SRC-1:0] src_clr;
    logic [HW_SRC-1:0] pend;
    logic              hw_ok;
    logic              any_req;
    vec_e              pick_vec;
    arb_state_t        st_d, st_q;
    logic              grant;

    intr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_n(irq_n),
        .fall_o (ext_fall)
    );

    assign src_set = {timer_req, ext_fall};

    for (genvar g = 0; g < HW_SRC; g++) begin : g_src
        assign src_clr[g] = ack & st_q.busy & (st_q.vsel == vec_of(g));
        intr_pend_latch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (src_set[g]),
            .clr_i (src_clr[g]),
            .pend_o(pend[g])
        );
    end

    intr_pick u_pick (
        .pend_i (pend),
        .mask_i (st_q.mask),
        .swi_i  (swi_decode),
        .hw_ok_o(hw_ok),
        .any_o  (any_req),
        .vec_o  (pick_vec)
    );

    always_comb begin
        st_d  = st_q;
        grant = instr_done & ~st_q.busy & any_req;
        st_d.take = grant;
        if (grant) begin
            st_d.vsel = pick_vec;
            st_d.busy = 1'b1;
            st_d.mask = 1'b1;
        end else begin
            if (ack)           st_d.busy = 1'b0;
            if (rti_restore_i) st_d.mask = rti_mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mask: 1'b1, take: 1'b0, busy: 1'b0, vsel: VEC_NONE};
        else        st_q <= st_d;
    end

    assign take_int   = st_q.take;
    assign vector_sel = st_q.vsel;
    assign mask_o     = st_q.mask;

    // R4
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> !take_int);

    // R4
    take_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_done |=> !take_int);

    // R5
    hw_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_int && (vector_sel == VEC_EXT || vector_sel == VEC_TMR) |-> !$past(mask_o));

    // R6
    ext_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done && !st_q.busy && !mask_o && pend[0] |=> take_int && vector_sel == VEC_EXT);

    // R7
    mask_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_int) |-> mask_o);

    // R8
    swi_any_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done && swi_decode && !st_q.busy |=> take_int);

    // R12
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_int |-> $stable(vector_sel));

endmodule

// File: tb/intr_arbiter_test.sv
module intr_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_n = 1'b1;
    logic       timer_req = 1'b0;
    logic       instr_done = 1'b0;
    logic       swi_decode = 1'b0;
    logic       rti_restore_i = 1'b0;
    logic       rti_mask_i = 1'b0;
    logic       ack = 1'b0;
    logic       take_int;
    logic [1:0] vector_sel;
    logic       mask_o;

    int    checks = 0;
    int    failures = 0;
    bit    done_flag = 0;
    string phase = "R1 reset";

    // behavioural reference state
    bit m_s1 = 1, m_s2 = 1, m_s3 = 1;
    bit m_ext = 0, m_tmr = 0, m_mask = 1, m_take = 0, m_busy = 0;
    int m_vsel = 0;

    always #10 clk = ~clk;

    intr_arbiter uut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .timer_req(timer_req),
        .instr_done(instr_done), .swi_decode(swi_decode),
        .rti_restore_i(rti_restore_i), .rti_mask_i(rti_mask_i), .ack(ack),
        .take_int(take_int), .vector_sel(vector_sel), .mask_o(mask_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_s3 = 1;
            m_ext = 0; m_tmr = 0; m_mask = 1; m_take = 0; m_busy = 0; m_vsel = 0;
        end else begin
            bit fall, clr_e, clr_t, hw, go;
            int nv;
            fall  = m_s3 && !m_s2;
            clr_e = ack && m_busy && m_vsel == 1;
            clr_t = ack && m_busy && m_vsel == 2;
            hw    = !m_mask && (m_ext || m_tmr);
            go    = instr_done && !m_busy && (hw || swi_decode);
            nv    = hw ? (m_ext ? 1 : 2) : 3;
            if (go) begin
                m_vsel = nv; m_mask = 1; m_busy = 1;
            end else begin
                if (ack) m_busy = 0;
                if (rti_restore_i) m_mask = rti_mask_i;
            end
            m_take = go;
            m_ext  = fall || (m_ext && !clr_e);
            m_tmr  = timer_req || (m_tmr && !clr_t);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk(take_int == m_take, {phase, " take_int"}, take_int, m_take);
        chk(vector_sel == m_vsel[1:0], {phase, " vector_sel"}, vector_sel, m_vsel);
        chk(mask_o == m_mask, {phase, " mask_o"}, mask_o, m_mask);
    endtask

    task automatic drive(input bit d, input bit s, input bit t, input bit a,
                         input bit r, input bit rm);
        instr_done = d; swi_decode = s; timer_req = t; ack = a;
        rti_restore_i = r; rti_mask_i = rm;
        tick();
        instr_done = 0; swi_decode = 0; timer_req = 0; ack = 0;
        rti_restore_i = 0; rti_mask_i = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic expect_out(input bit tk, input int v, input bit mk, input string req);
        chk(take_int == tk, {req, " take"}, take_int, tk);
        chk(vector_sel == v[1:0], {req, " vec"}, vector_sel, v);
        chk(mask_o == mk, {req, " mask"}, mask_o, mk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        phase = "R1 reset";
        expect_out(0, 0, 1, "R1");
        drive(0, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0, 0);
        expect_out(0, 0, 0, "R1 no pending");
        drive(0, 0, 0, 0, 1, 1);

        phase = "R2 R5 masked edge";
        irq_n = 0; idle(5);
        drive(1, 0, 0, 0, 0, 0);
        expect_out(0, 0, 1, "R5 masked no grant");
        drive(0, 0, 0, 0, 1, 0);
        idle(1);
        expect_out(0, 0, 0, "R4 no boundary");
        drive(1, 0, 0, 0, 0, 0);
        expect_out(1, 1, 1, "R2 R7 ext grant");
        idle(1);
        expect_out(0, 1, 1, "R4 pulse");
        drive(0, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0, 0);
        expect_out(0, 1, 0, "R2 low level no retrigger");
        irq_n = 1; idle(4);

        phase = "R3 timer";
        drive(0, 0, 1, 0, 0, 0);
        drive(1, 0, 0, 0, 0, 0);
        expect_out(1, 2, 1, "R3 timer grant");
        drive(0, 0, 0, 1, 0, 0);
        idle(2);
        expect_out(0, 2, 1, "R12 vec held");

        phase = "R6 R11 both";
        drive(0, 0, 0, 0, 1, 0);
        irq_n = 0;
        drive(0, 0, 1, 0, 0, 0);
        idle(4);
        drive(1, 0, 0, 0, 0, 0);
        expect_out(1, 1, 1, "R6 ext first");
        drive(0, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0, 0);
        expect_out(0, 1, 0, "R11 busy blocks");
        drive(0, 0, 0, 1, 0, 0);
        drive(1, 0, 0, 0, 0, 0);
        expect_out(1, 2, 1, "R6 R10 timer kept");
        drive(0, 0, 0, 1, 0, 0);
        irq_n = 1; idle(4);

        phase = "R8 software";
        drive(1, 1, 0, 0, 0, 0);
        expect_out(1, 3, 1, "R8 swi masked");
        drive(0, 0, 0, 1, 0, 0);
        drive(0, 0, 1, 0, 1, 0);
        drive(1, 1, 0, 0, 0, 0);
        expect_out(1, 2, 1, "R8 hw beats swi");
        drive(0, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0, 0);
        expect_out(0, 2, 0, "R10 cleared by ack");

        phase = "R10 stray ack";
        drive(0, 0, 1, 0, 1, 1);
        drive(0, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0, 0);
        expect_out(1, 2, 1, "R10 stray ack ignored");
        drive(0, 0, 1, 1, 0, 0);
        drive(0, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 0, 0);
        expect_out(1, 2, 1, "R10 set beats clear");
        drive(0, 0, 0, 1, 0, 0);

        phase = "R9 restore";
        drive(0, 0, 1, 0, 1, 0);
        expect_out(0, 2, 0, "R9 restore 0");
        drive(1, 0, 0, 0, 1, 0);
        expect_out(1, 2, 1, "R9 grant beats restore");
        drive(0, 0, 0, 1, 1, 1);
        expect_out(0, 2, 1, "R9 restore 1");

        phase = "R4 R5 R10 random";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 11) == 0) irq_n = ~irq_n;
            drive($urandom_range(0, 2) == 0, $urandom_range(0, 7) == 0,
                  $urandom_range(0, 9) == 0, $urandom_range(0, 5) == 0,
                  $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);
        end

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule